// File: doc/BRIEF.md
# Integer Execution Unit with Stored Compare Flags

This block is the arithmetic and logic datapath of a small 32-bit processor. Each cycle it takes an operation code and two operands and produces a combinational result. It covers wrapping add and subtract, both in register and immediate form, increment, decrement, seven bitwise functions, and logical shifts in both directions. The operand multiplexing that supplies a register value or a decoded immediate on `opnd_b` sits outside the block.

A compare operation writes a small flag register on the clock edge. The flag register records a signed three-way ordering of the two operands, together with its two inclusive forms. A separate condition input chooses one of the jump conditions. The `br_taken` output reports, combinationally from the stored flags, whether that jump goes ahead. The program-counter logic uses this output to select the jump target.

Top module: `exec_alu`

## Requirements
- R1: ADD (0) and ADDI (2) give `opnd_a + opnd_b`, and SUB (1) and SUBI (3) give `opnd_a - opnd_b`. All four wrap modulo 2^WIDTH and raise no overflow indication.
- R2: INC (4) gives `opnd_a + 1` and DEC (5) gives `opnd_a - 1`. Both wrap.
- R3: The logic codes are AND (6), OR (7), XOR (8), NOT of A (9), NAND (10), NOR (11) and XNOR (12). Each gives the bitwise function of A and B.
- R4: SHL (13) shifts A left by the low 5 bits of B. The higher bits of B are ignored.
- R5: SHR (14) shifts A right by the low 5 bits of B and fills with zeros. Bit 31 of A is never copied into the vacated bits.
- R6: CMP (15) treats A and B as signed two's complement. On the next clock edge it loads `flags` as follows: bit0 equal, bit1 A>B, bit2 A<B, bit3 A>=B, bit4 A<=B.
- R7: The flag register changes only on a CMP. Every other operation leaves `flags` unchanged.
- R8: `br_taken` follows `cond` using the stored flags. The codes are 0 always, 1 equal, 2 not equal (the inverse of bit0), 3 greater, 4 greater-or-equal, 5 less, 6 less-or-equal, and 7 never.
- R9: Reset clears `flags` to 0. With cleared flags only cond 0 and cond 2 are taken.
- R10: During CMP the `result` output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op | input | 4 | Operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, register value or immediate; supplies the shift amount |
| cond | input | 3 | Jump condition code |
| result | output | 32 | Combinational result |
| flags | output | 5 | Stored compare flags |
| br_taken | output | 1 | Jump condition satisfied |

## Verification
The bench builds the block at its default WIDTH of 32. At that width the shift mask of five bits and the sign bit at position 31 are the cases that matter. This makes wrap at 0xFFFFFFFF, a shift amount of 35 aliasing to 3, and compares between 0x80000000 and small positive values reachable as directed cases. A random stream then mixes compares with other operations and all eight conditions, so flag retention and condition selection are exercised after many different histories.

// File: rtl/exec_alu.sv
module exec_alu #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [2:0]       cond,
  output logic [WIDTH-1:0] result,
  output logic [4:0]       flags,
  output logic             br_taken
);
  localparam int SHW = $clog2(WIDTH);
  localparam logic [3:0] OP_CMP = 4'd15;

  logic [SHW-1:0] sh_amt;
  logic           is_cmp;
  logic           f_eq, f_gt, f_lt;
  logic [4:0]     flags_q;

  assign sh_amt = opnd_b[SHW-1:0];
  assign is_cmp = (op == OP_CMP);

  always_comb begin
    case (op)
      4'd0, 4'd2:  result = opnd_a + opnd_b;
      4'd1, 4'd3:  result = opnd_a - opnd_b;
      4'd4:        result = opnd_a + 1'b1;
      4'd5:        result = opnd_a - 1'b1;
      4'd6:        result = opnd_a & opnd_b;
      4'd7:        result = opnd_a | opnd_b;
      4'd8:        result = opnd_a ^ opnd_b;
      4'd9:        result = ~opnd_a;
      4'd10:       result = ~(opnd_a & opnd_b);
      4'd11:       result = ~(opnd_a | opnd_b);
      4'd12:       result = ~(opnd_a ^ opnd_b);
      4'd13:       result = opnd_a << sh_amt;
      4'd14:       result = opnd_a >> sh_amt;
      default:     result = '0;
    endcase
  end

  assign f_eq = (opnd_a == opnd_b);
  assign f_lt = ($signed(opnd_a) < $signed(opnd_b));
  assign f_gt = !f_eq && !f_lt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flags_q <= '0;
    else if (is_cmp) flags_q <= {f_eq | f_lt, f_eq | f_gt, f_lt, f_gt, f_eq};
  end

  assign flags = flags_q;

  always_comb begin
    case (cond)
      3'd0:    br_taken = 1'b1;
      3'd1:    br_taken = flags_q[0];
      3'd2:    br_taken = !flags_q[0];
      3'd3:    br_taken = flags_q[1];
      3'd4:    br_taken = flags_q[3];
      3'd5:    br_taken = flags_q[2];
      3'd6:    br_taken = flags_q[4];
      default: br_taken = 1'b0;
    endcase
  end

  p_flags_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !is_cmp |=> $stable(flags));

  p_cmp_eq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmp |=> flags[0] == ($past(opnd_a) == $past(opnd_b)));

  p_order_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flags[2:0]));

  p_always_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cond == 3'd0) |-> br_taken);

  p_cmp_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmp |-> (result == '0));

  always_comb begin
    if (rst_n && (op == 4'd14) && (sh_amt != '0))
      p_shr_zero_fill_r5: assert (result[WIDTH-1] == 1'b0);
  end
endmodule

// File: tb/sim_exec_alu.sv
`timescale 1ns/1ps
module sim_exec_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [2:0]  cond = 3'd0;
  logic [31:0] result;
  logic [4:0]  flags;
  logic        br_taken;

  int compared = 0;
  int mismatched = 0;
  logic [4:0] m_flags = '0;

  always #4 clk = ~clk;

  exec_alu #(.WIDTH(32)) u0 (
    .clk(clk), .rst_n(rst_n), .op(op), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .cond(cond), .result(result), .flags(flags), .br_taken(br_taken)
  );

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0, 4'd1, 4'd2, 4'd3: return "R1";
      4'd4, 4'd5:             return "R2";
      4'd13:                  return "R4";
      4'd14:                  return "R5";
      4'd15:                  return "R10";
      default:                return "R3";
    endcase
  endfunction

  function automatic logic [31:0] model_res(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b);
    int s;
    s = b % 32;
    case (o)
      4'd0, 4'd2: return a + b;
      4'd1, 4'd3: return a - b;
      4'd4:  return a + 32'd1;
      4'd5:  return a - 32'd1;
      4'd6:  return a & b;
      4'd7:  return a | b;
      4'd8:  return a ^ b;
      4'd9:  return ~a;
      4'd10: return ~(a & b);
      4'd11: return ~(a | b);
      4'd12: return ~(a ^ b);
      4'd13: return a << s;
      4'd14: return a >> s;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic model_taken(input logic [2:0] c, input logic [4:0] f);
    case (c)
      3'd0: return 1'b1;
      3'd1: return f[0];
      3'd2: return !f[0];
      3'd3: return f[1];
      3'd4: return f[3];
      3'd5: return f[2];
      3'd6: return f[4];
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b, input logic [2:0] c);
    integer sa, sb;
    @(negedge clk);
    op = o; opnd_a = a; opnd_b = b; cond = c;
    #1;
    check(req_of(o), result, model_res(o, a, b));
    check("R7", {27'd0, flags}, {27'd0, m_flags});
    check("R8", {31'd0, br_taken}, {31'd0, model_taken(c, m_flags)});
    if (o == 4'd15) begin
      sa = $signed(a); sb = $signed(b);
      m_flags = {sa <= sb, sa >= sb, sa < sb, sa > sb, sa == sb};
    end
  endtask

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9", {27'd0, flags}, 32'd0);
    for (int c = 0; c < 8; c++) begin
      cond = c[2:0]; #1;
      check("R9", {31'd0, br_taken}, {31'd0, (c == 0 || c == 2)});
    end
    @(negedge clk); rst_n = 1'b1;

    step(4'd0, 32'hFFFFFFFF, 32'd1, 3'd0);
    step(4'd3, 32'd0, 32'd1, 3'd1);
    step(4'd4, 32'hFFFFFFFF, 32'd0, 3'd2);
    step(4'd5, 32'd0, 32'd0, 3'd7);
    step(4'd13, 32'h0000_0001, 32'd35, 3'd0);
    step(4'd13, 32'h1234_5678, 32'hFFFF_FFE0, 3'd0);
    step(4'd14, 32'h8000_0000, 32'd31, 3'd0);
    step(4'd14, 32'hF000_000F, 32'd4, 3'd0);
    step(4'd10, 32'hF0F0_F0F0, 32'hFF00_FF00, 3'd0);
    step(4'd11, 32'hF0F0_F0F0, 32'h0F0F_0000, 3'd0);
    step(4'd12, 32'hAAAA_5555, 32'hAAAA_AAAA, 3'd0);
    step(4'd15, 32'h8000_0000, 32'd1, 3'd0);
    for (int c = 0; c < 8; c++) step(4'd0, 32'd5, 32'd7, c[2:0]);
    step(4'd15, 32'd42, 32'd42, 3'd0);
    for (int c = 0; c < 8; c++) step(4'd8, 32'd1, 32'd2, c[2:0]);
    step(4'd15, 32'd7, 32'hFFFF_FFFF, 3'd0);
    for (int c = 0; c < 8; c++) step(4'd9, 32'd3, 32'd0, c[2:0]);

    for (int i = 0; i < 600; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom; rb = $urandom;
      if (i % 5 == 0) rb = ra;
      if (i % 7 == 0) rb = {ra[31], rb[30:0]};
      step(4'($urandom % 16), ra, rb, 3'($urandom % 8));
    end

    @(negedge clk); #1;
    check("R7", {27'd0, flags}, {27'd0, m_flags});
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule